// File: doc/BRIEF.md
# One-Bit Compressive Back-Projection Unit

This block rebuilds a sparse signal estimate from one-bit compressive measurements. Each measurement is a single sign bit. It arrives together with the matching row of a sign-only sensing matrix, one bit per signal element. For every element the unit keeps a signed running sum. The sum moves up by one when the element's matrix bit agrees with the measurement bit and down by one when it disagrees. This is the product of the transposed ±1 matrix with the measurement vector, computed with XNOR and add logic only.

A start pulse clears the sums and sets the measurement count m = 2^log2m and the sparsity s. Once exactly m measurements have been accepted, the unit runs s selection passes, one per clock. Each pass picks the largest remaining magnitude and emits its element index and its scaled value. Elements that are never emitted count as zero in the estimate. A done flag marks the end of the stream.

The value is divided by m through a shift and is returned with a fixed number of fraction bits. No precision is lost for any allowed m.

Top module: `bp_backproj`

## Requirements
- R1: While reset is applied and after it is released, out_valid and done are 0 until a run produces output.
- R2: A start pulse clears all element sums, loads m = 2^log2m (log2m from 0 to 8) and s = s_keep (0 to 8), and drops done in the following cycle.
- R3: For each accepted measurement, the sum of element i grows by +1 when row_bits[i] equals meas_bit, and by -1 otherwise.
- R4: Exactly m measurements are accepted, on cycles with meas_valid high. A meas_valid while no accumulation is running is ignored, including during the output stream.
- R5: When start and meas_valid are high in the same cycle, start takes priority and that measurement is discarded.
- R6: After the m-th measurement, exactly s (index, value) pairs appear on s consecutive cycles. out_valid is high on each of them. Their magnitudes do not increase, and no index repeats.
- R7: Among equal magnitudes, the lower element index is emitted first.
- R8: out_value equals the element sum times 2^(8 - log2m) in two's complement. This is the sum divided by m, with 8 fraction bits, so its magnitude never exceeds 256.
- R9: done rises in the cycle after the last pair (or after the m-th measurement when s = 0). It stays high until the next start, and it is never high together with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears sums and begins a new run |
| log2m | input | 4 | Base-2 log of the measurement count, sampled on start |
| s_keep | input | 4 | Number of coefficients to keep, sampled on start |
| meas_valid | input | 1 | Measurement strobe |
| meas_bit | input | 1 | Sign bit of the measurement (1 = positive) |
| row_bits | input | 32 | Sign bits of the matching sensing-matrix row, bit i for element i |
| out_valid | output | 1 | An (index, value) pair is present |
| out_index | output | 5 | Element index of the pair |
| out_value | output | 10 | Scaled coefficient, two's complement with 8 fraction bits |
| done | output | 1 | Stream finished; held until the next start |

## Verification
Two pairs of functions can meet in the same cycle. The first is a start pulse arriving together with a measurement strobe. The bench raises both at once, with a row that would push every sum upward, and then requires the stream to match a model that never saw that measurement. The second is the output stream running while the measurement strobe stays active. The bench keeps meas_valid toggling with junk rows for the whole stream and requires the emitted values to equal those computed from the m accepted measurements alone. Each pair is matched against a scoreboard entry; the order follows the model's tie rule and the values are checked down to the fraction bits.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int unsigned BP_ELEMS    = 32;
    localparam int unsigned BP_LOGM_MAX = 8;
    localparam int unsigned BP_KEEP_MAX = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_PICK  = 2'd2
    } bp_state_e;

    // +1 when the matrix sign agrees with the measurement sign, -1 otherwise
    function automatic logic signed [1:0] sign_vote(input logic row_bit, input logic meas_bit);
        return (row_bit ~^ meas_bit) ? 2'sd1 : -2'sd1;
    endfunction

endpackage

// File: rtl/bp_accum_bank.sv
module bp_accum_bank
    import bp_pkg::*;
#(
    parameter int unsigned ELEMS = 32,
    parameter int unsigned ACC_W = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        en,
    input  logic                        meas_bit,
    input  logic [ELEMS-1:0]            row_bits,
    output logic [ELEMS-1:0][ACC_W-1:0] acc
);

    for (genvar gi = 0; gi < ELEMS; gi++) begin : g_elem
        logic signed [1:0]  vote;
        logic [ACC_W-1:0]   sum_q;

        assign vote = sign_vote(row_bits[gi], meas_bit);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                sum_q <= '0;
            end else if (en) begin
                sum_q <= sum_q + {{(ACC_W-2){vote[1]}}, vote};
            end
        end

        assign acc[gi] = sum_q;
    end

endmodule

// File: rtl/bp_peak_pick.sv
module bp_peak_pick #(
    parameter int unsigned ELEMS = 32,
    parameter int unsigned ACC_W = 10,
    parameter int unsigned IDX_W = 5
) (
    input  logic [ELEMS-1:0][ACC_W-1:0] acc,
    input  logic [ELEMS-1:0]            taken,
    output logic [IDX_W-1:0]            best_idx,
    output logic                        found
);

    logic [ACC_W-1:0] best_mag;
    logic [ACC_W-1:0] mag;

    // ascending scan with strict compare keeps the lower index on ties
    always_comb begin
        best_mag = '0;
        best_idx = '0;
        found    = 1'b0;
        mag      = '0;
        for (int i = 0; i < ELEMS; i++) begin
            mag = acc[i][ACC_W-1] ? (~acc[i] + 1'b1) : acc[i];
            if (!taken[i] && (!found || (mag > best_mag))) begin
                found    = 1'b1;
                best_mag = mag;
                best_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bp_backproj.sv
module bp_backproj
    import bp_pkg::*;
#(
    parameter int unsigned ELEMS    = BP_ELEMS,
    parameter int unsigned LOGM_MAX = BP_LOGM_MAX,
    parameter int unsigned KEEP_MAX = BP_KEEP_MAX
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic [$clog2(LOGM_MAX+1)-1:0]   log2m,
    input  logic [$clog2(KEEP_MAX+1)-1:0]   s_keep,
    input  logic                            meas_valid,
    input  logic                            meas_bit,
    input  logic [ELEMS-1:0]                row_bits,
    output logic                            out_valid,
    output logic [$clog2(ELEMS)-1:0]        out_index,
    output logic [LOGM_MAX+1:0]             out_value,
    output logic                            done
);

    localparam int unsigned ACC_W  = LOGM_MAX + 2;
    localparam int unsigned IDX_W  = $clog2(ELEMS);
    localparam int unsigned LOGM_W = $clog2(LOGM_MAX + 1);
    localparam int unsigned KEEP_W = $clog2(KEEP_MAX + 1);
    localparam int unsigned CNT_W  = LOGM_MAX + 1;

    bp_state_e                  state;
    logic [LOGM_W-1:0]          logm_q;
    logic [KEEP_W-1:0]          keep_q;
    logic [KEEP_W-1:0]          pass_q;
    logic [CNT_W-1:0]           meas_cnt;
    logic [CNT_W-1:0]           last_cnt;
    logic [ELEMS-1:0]           taken;
    logic                       take_meas;
    logic [ELEMS-1:0][ACC_W-1:0] acc;
    logic [IDX_W-1:0]           best_idx;
    logic                       found;
    logic [LOGM_W-1:0]          shamt;
    logic [ACC_W-1:0]           scaled;

    assign take_meas = (state == ST_ACCUM) && meas_valid && !start;
    assign last_cnt  = (CNT_W'(1) << logm_q) - CNT_W'(1);
    assign shamt     = LOGM_W'(LOGM_MAX) - logm_q;
    assign scaled    = acc[best_idx] << shamt;

    bp_accum_bank #(
        .ELEMS (ELEMS),
        .ACC_W (ACC_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .clr      (start),
        .en       (take_meas),
        .meas_bit (meas_bit),
        .row_bits (row_bits),
        .acc      (acc)
    );

    bp_peak_pick #(
        .ELEMS (ELEMS),
        .ACC_W (ACC_W),
        .IDX_W (IDX_W)
    ) u_pick (
        .acc      (acc),
        .taken    (taken),
        .best_idx (best_idx),
        .found    (found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            logm_q    <= '0;
            keep_q    <= '0;
            pass_q    <= '0;
            meas_cnt  <= '0;
            taken     <= '0;
            out_valid <= 1'b0;
            out_index <= '0;
            out_value <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (start) begin
                state    <= ST_ACCUM;
                logm_q   <= log2m;
                keep_q   <= s_keep;
                pass_q   <= '0;
                meas_cnt <= '0;
                taken    <= '0;
                done     <= 1'b0;
            end else begin
                case (state)
                    ST_ACCUM: begin
                        if (meas_valid) begin
                            meas_cnt <= meas_cnt + 1'b1;
                            if (meas_cnt == last_cnt) begin
                                state <= ST_PICK;
                            end
                        end
                    end
                    ST_PICK: begin
                        if ((pass_q == keep_q) || !found) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            out_valid       <= 1'b1;
                            out_index       <= best_idx;
                            out_value       <= scaled;
                            taken[best_idx] <= 1'b1;
                            pass_q          <= pass_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/bp_backproj_chk.sv
module bp_backproj_chk #(
    parameter int unsigned ELEMS    = 32,
    parameter int unsigned LOGM_MAX = 8,
    parameter int unsigned KEEP_MAX = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     out_valid,
    input logic [$clog2(ELEMS)-1:0] out_index,
    input logic [LOGM_MAX+1:0]      out_value,
    input logic                     done
);

    localparam int unsigned ACC_W = LOGM_MAX + 2;

    logic [ACC_W-1:0] mag_now;
    logic [ACC_W-1:0] mag_prev;
    logic [7:0]       pairs_seen;

    assign mag_now = out_value[ACC_W-1] ? (~out_value + 1'b1) : out_value;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            pairs_seen <= '0;
            mag_prev   <= '0;
        end else if (out_valid) begin
            pairs_seen <= pairs_seen + 1'b1;
            mag_prev   <= mag_now;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!out_valid && !done));

    // R2
    a_r2_start_clears_done: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !out_valid));

    // R9
    a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(done && out_valid));

    // R6
    a_r6_descending: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (mag_now <= mag_prev));

    // R6
    a_r6_pair_budget: assert property (@(posedge clk) disable iff (rst)
        pairs_seen <= 8'(KEEP_MAX));

    // R8
    a_r8_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (mag_now <= ACC_W'(1 << LOGM_MAX)));

endmodule

bind bp_backproj bp_backproj_chk #(
    .ELEMS    (ELEMS),
    .LOGM_MAX (LOGM_MAX),
    .KEEP_MAX (KEEP_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .out_valid (out_valid),
    .out_index (out_index),
    .out_value (out_value),
    .done      (done)
);

// File: tb/sim_bp_backproj.sv
`timescale 1ns/1ps
module sim_bp_backproj;

    localparam int ELEMS = 32;
    localparam int WDOG  = 150000;

    typedef struct {
        int idx;
        int val;
    } pair_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [3:0]        log2m = '0;
    logic [3:0]        s_keep = '0;
    logic              meas_valid = 1'b0;
    logic              meas_bit = 1'b0;
    logic [ELEMS-1:0]  row_bits = '0;
    logic              out_valid;
    logic [4:0]        out_index;
    logic [9:0]        out_value;
    logic              done;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    pair_t sb[$];

    always #10 clk = ~clk;

    bp_backproj u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .log2m      (log2m),
        .s_keep     (s_keep),
        .meas_valid (meas_valid),
        .meas_bit   (meas_bit),
        .row_bits   (row_bits),
        .out_valid  (out_valid),
        .out_index  (out_index),
        .out_value  (out_value),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
            finish_run();
        end
    end

    // monitor: pops the scoreboard for every emitted pair (R6, R7, R8)
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected pair", int'(out_index), -1);
            end else begin
                pair_t e;
                e = sb.pop_front();
                check(int'(out_index) == e.idx, "R6/R7 index", int'(out_index), e.idx);
                check(int'($signed(out_value)) == e.val, "R8 value", int'($signed(out_value)), e.val);
            end
        end
    end

    // mode 0 random rows, 1 all agree, 2 all disagree, 3 elements 0..3 always agree
    task automatic run_case(input int lg, input int keep, input int mode, input bit stray);
        int model[ELEMS];
        bit used[ELEMS];
        int m;
        m = 1 << lg;
        for (int i = 0; i < ELEMS; i++) begin
            model[i] = 0;
            used[i]  = 1'b0;
        end
        @(negedge clk);
        start      = 1'b1;
        log2m      = 4'(lg);
        s_keep     = 4'(keep);
        meas_valid = stray;   // R5: must be discarded
        meas_bit   = 1'b1;
        row_bits   = '1;
        @(negedge clk);
        start      = 1'b0;
        meas_valid = 1'b0;
        check(done == 1'b0, "R2 done cleared", int'(done), 0);
        for (int j = 0; j < m; j++) begin
            logic           mb;
            logic [ELEMS-1:0] rw;
            mb = 1'($urandom);
            case (mode)
                1:       rw = {ELEMS{mb}};
                2:       rw = {ELEMS{~mb}};
                3:       rw = {$urandom} & ~32'hF | {28'd0, {4{mb}}};
                default: rw = $urandom;
            endcase
            if ((j % 5) == 2) begin
                meas_valid = 1'b0;
                @(negedge clk);
            end
            meas_valid = 1'b1;
            meas_bit   = mb;
            row_bits   = rw;
            // R3: +1 on agreement, -1 otherwise
            for (int i = 0; i < ELEMS; i++) begin
                model[i] += (rw[i] == mb) ? 1 : -1;
            end
            @(negedge clk);
        end
        for (int p = 0; p < keep; p++) begin
            int best;
            int bmag;
            pair_t e;
            best = -1;
            bmag = -1;
            for (int i = 0; i < ELEMS; i++) begin
                int a;
                a = (model[i] < 0) ? -model[i] : model[i];
                if (!used[i] && a > bmag) begin
                    bmag = a;
                    best = i;
                end
            end
            used[best] = 1'b1;
            e.idx = best;
            e.val = model[best] * (1 << (8 - lg));
            sb.push_back(e);
        end
        // R4: strobes during the stream are ignored
        for (int k = 0; k < keep + 2; k++) begin
            meas_valid = 1'($urandom);
            meas_bit   = 1'($urandom);
            row_bits   = $urandom;
            @(negedge clk);
        end
        meas_valid = 1'b0;
        for (int k = 0; k < 40 && !done; k++) @(negedge clk);
        check(done == 1'b1, "R9 done raised", int'(done), 1);
        check(sb.size() == 0, "R6 pair count", sb.size(), 0);
        sb.delete();
        repeat (3) @(negedge clk);
        check(done == 1'b1 && out_valid == 1'b0, "R9 done held", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && done == 1'b0, "R1 idle after reset", int'(done), 0);
        run_case(4, 4, 0, 1'b0);
        run_case(0, 1, 1, 1'b0);   // m = 1, value +256
        run_case(2, 3, 2, 1'b1);   // all negative, ties, start/strobe collision
        run_case(5, 8, 3, 1'b0);   // R7: four tied leaders
        run_case(3, 0, 0, 1'b0);   // s = 0
        run_case(6, 5, 0, 1'b1);
        run_case(1, 2, 0, 1'b0);
        run_case(8, 8, 0, 1'b0);   // m = 256
        finish_run();
    end

endmodule